// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits next to a processor core and decides which pending interrupt request the core should take next. Every source has a fixed class, set by its source number. A small group of top-level sources can never be masked. A second top-level group is masked by the core's level and by its enable bit. The ordinary sources each carry a programmable two-bit level. One software-only source sits below all of them. The core reports the level of the handler it is running. A request is forwarded only if it ranks strictly above that level, so a higher-priority request can preempt a running handler.

The winning request is presented with its source number, its rank and a handler address. The address is normally the relocatable table base plus twice the source number. Two fast slots can each be pointed at any source number; a slot supplies a direct handler address instead. A wake output tells the clock and system control logic that some enabled request is pending, whether or not the mask lets it through, so the system can leave a wait or stop state. All outputs are registered, one cycle after the inputs. Saving state on the stack and fetching the vector belong to the core.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: Sources 0 to NUM_NMI-1 (0..3 by default) rank as level 3. They are accepted whatever the values of `core_mask_i` and the enables.
- R3: Sources NUM_NMI to NUM_NMI+NUM_ML3-1 (4..6) rank as level 3. They are taken only when their enable bit is set and `core_mask_i` is below 5. The enable bit of source i is `en_i[i-NUM_NMI]`.
- R4: Ordinary sources 7..14 take their level from field `lvl_cfg_i[2*(i-7)+:2]`, where code 0 is level 0, code 1 is level 1 and code 2 is level 2. Code 3, or a cleared enable bit, makes the source ignored.
- R5: The last source (15) is the software lowest level. It is taken when enabled and `core_mask_i` is 0.
- R6: Ranks are encoded as LP=1, level0=2, level1=3, level2=4, level3=5. `core_mask_i` uses the same scale, with 0 meaning nothing is masked. A maskable request is accepted only if its rank is strictly greater than `core_mask_i`.
- R7: Among accepted requests the highest rank wins. On equal rank the lowest source number wins. `irq_lvl_o` reports the winner's rank.
- R8: When no fast slot matches, `irq_vec_o` equals `vec_base_i + 2*irq_src_o`, modulo 2^ADDR_W.
- R9: If slot 0 is enabled (`fast_en_i[0]`) and its source equals the winner, `irq_vec_o` is `fast_addr0_i` and `irq_fast_o` is 1. Failing that, slot 1 is checked in the same way. Slot 0 takes precedence.
- R10: `wake_o` is 1 when any request is eligible regardless of `core_mask_i`. A request is eligible if it is unmaskable, or if it is enabled and, for ordinary sources, its code is not 3.
- R11: The outputs reflect the inputs sampled at the previous clock edge. When `irq_valid_o` is 0, `irq_src_o`, `irq_lvl_o`, `irq_vec_o` and `irq_fast_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Level request per source |
| en_i | input | NUM_SRC-NUM_NMI | Enable for each maskable source |
| lvl_cfg_i | input | 2*NUM_USR | Two-bit level code per ordinary source |
| core_mask_i | input | 3 | Rank of the handler the core is running |
| vec_base_i | input | ADDR_W | Vector table base |
| fast_en_i | input | 2 | Enable for fast slots 0 and 1 |
| fast_src0_i | input | SRC_W | Source mapped to fast slot 0 |
| fast_src1_i | input | SRC_W | Source mapped to fast slot 1 |
| fast_addr0_i | input | ADDR_W | Handler address of fast slot 0 |
| fast_addr1_i | input | ADDR_W | Handler address of fast slot 1 |
| irq_valid_o | output | 1 | A request is forwarded to the core |
| irq_src_o | output | SRC_W | Winning source number |
| irq_lvl_o | output | 3 | Winning rank |
| irq_vec_o | output | ADDR_W | Handler address |
| irq_fast_o | output | 1 | Address came from a fast slot |
| wake_o | output | 1 | Eligible request pending |

## Verification
Directed patterns come first:
- A lone ordinary request at each level, swept against masks just below and at its rank. This separates strict from non-strict acceptance.
- Pairs at equal and at unequal levels. These separate rank order from number order.
- A maskable top-level request next to an unmaskable one under the highest mask. This separates the two top-level classes.
- Both fast slots mapped to the same source, then one at a time. This exposes the slot precedence.
- Masked but enabled requests. These show wake raised while no interrupt is forwarded.

Random words of requests, enables, codes, masks and slot settings then drive the controller. A behavioural model compares every output on every cycle.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int RANK_W = 3;

    typedef enum logic [RANK_W-1:0] {
        RK_NONE = 3'd0,
        RK_LP   = 3'd1,
        RK_L0   = 3'd2,
        RK_L1   = 3'd3,
        RK_L2   = 3'd4,
        RK_L3   = 3'd5
    } rank_e;

    typedef enum logic [1:0] {
        CLS_NMI,
        CLS_ML3,
        CLS_USER,
        CLS_SWLP
    } src_class_e;

    // Class of a source is fixed by its number.
    function automatic src_class_e class_of(input int idx, input int nmi,
                                            input int ml3, input int nsrc);
        if (idx < nmi)            return CLS_NMI;
        else if (idx < nmi + ml3) return CLS_ML3;
        else if (idx == nsrc - 1) return CLS_SWLP;
        else                      return CLS_USER;
    endfunction

    // Two-bit user code to rank; code 3 removes the source.
    function automatic rank_e user_rank(input logic [1:0] code);
        case (code)
            2'd0:    return RK_L0;
            2'd1:    return RK_L1;
            2'd2:    return RK_L2;
            default: return RK_NONE;
        endcase
    endfunction

    typedef struct packed {
        logic hit0;
        logic hit1;
    } fast_hit_t;

endpackage

// File: rtl/nic_rank_map.sv
module nic_rank_map
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_NMI = 4,
    parameter int NUM_ML3 = 3,
    localparam int NUM_MSK = NUM_SRC - NUM_NMI,
    localparam int NUM_USR = NUM_SRC - NUM_NMI - NUM_ML3 - 1
) (
    input  logic [NUM_SRC-1:0]        req_i,
    input  logic [NUM_MSK-1:0]        en_i,
    input  logic [2*NUM_USR-1:0]      lvl_cfg_i,
    output logic [RANK_W*NUM_SRC-1:0] rank_flat_o,
    output logic [NUM_SRC-1:0]        unmask_o,
    output logic                      wake_o
);

    logic [NUM_SRC-1:0] elig;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        rank_e rk;
        if (i < NUM_NMI) begin : g_nmi
            assign rk = RK_L3;
            assign unmask_o[i] = 1'b1;
        end else if (i < NUM_NMI + NUM_ML3) begin : g_ml3
            assign rk = en_i[i-NUM_NMI] ? RK_L3 : RK_NONE;
            assign unmask_o[i] = 1'b0;
        end else if (i == NUM_SRC - 1) begin : g_swlp
            assign rk = en_i[i-NUM_NMI] ? RK_LP : RK_NONE;
            assign unmask_o[i] = 1'b0;
        end else begin : g_user
            assign rk = en_i[i-NUM_NMI]
                        ? user_rank(lvl_cfg_i[2*(i-NUM_NMI-NUM_ML3) +: 2])
                        : RK_NONE;
            assign unmask_o[i] = 1'b0;
        end
        assign elig[i] = req_i[i] && (rk != RK_NONE);
        assign rank_flat_o[RANK_W*i +: RANK_W] = elig[i] ? rk : RK_NONE;
    end

    assign wake_o = |elig;

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int SRC_W = $clog2(NUM_SRC)
) (
    input  logic [RANK_W*NUM_SRC-1:0] rank_flat_i,
    input  logic [NUM_SRC-1:0]        unmask_i,
    input  logic [RANK_W-1:0]         core_mask_i,
    output logic                      win_valid_o,
    output logic [SRC_W-1:0]          win_src_o,
    output logic [RANK_W-1:0]         win_rank_o
);

    always_comb begin
        win_valid_o = 1'b0;
        win_src_o   = '0;
        win_rank_o  = '0;
        // Ascending scan with a strict compare keeps the lowest number on ties.
        for (int i = 0; i < NUM_SRC; i++) begin
            logic [RANK_W-1:0] r;
            logic              ok;
            r  = rank_flat_i[RANK_W*i +: RANK_W];
            ok = (r != '0) && (unmask_i[i] || (r > core_mask_i));
            if (ok && (r > win_rank_o)) begin
                win_valid_o = 1'b1;
                win_src_o   = SRC_W'(i);
                win_rank_o  = r;
            end
        end
    end

endmodule

// File: rtl/nic_vector.sv
module nic_vector
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 16,
    localparam int SRC_W = $clog2(NUM_SRC)
) (
    input  logic              win_valid_i,
    input  logic [SRC_W-1:0]  win_src_i,
    input  logic [ADDR_W-1:0] vec_base_i,
    input  logic [1:0]        fast_en_i,
    input  logic [SRC_W-1:0]  fast_src0_i,
    input  logic [SRC_W-1:0]  fast_src1_i,
    input  logic [ADDR_W-1:0] fast_addr0_i,
    input  logic [ADDR_W-1:0] fast_addr1_i,
    output logic [ADDR_W-1:0] vec_o,
    output logic              fast_o
);

    fast_hit_t hit;

    assign hit.hit0 = win_valid_i && fast_en_i[0] && (win_src_i == fast_src0_i);
    assign hit.hit1 = win_valid_i && fast_en_i[1] && (win_src_i == fast_src1_i);

    always_comb begin
        if (!win_valid_i)  vec_o = '0;
        else if (hit.hit0) vec_o = fast_addr0_i;
        else if (hit.hit1) vec_o = fast_addr1_i;
        else               vec_o = vec_base_i + (ADDR_W'(win_src_i) << 1);
    end

    assign fast_o = hit.hit0 || hit.hit1;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_NMI = 4,
    parameter int NUM_ML3 = 3,
    parameter int ADDR_W  = 16,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int NUM_MSK = NUM_SRC - NUM_NMI,
    localparam int NUM_USR = NUM_SRC - NUM_NMI - NUM_ML3 - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  req_i,
    input  logic [NUM_MSK-1:0]  en_i,
    input  logic [2*NUM_USR-1:0] lvl_cfg_i,
    input  logic [2:0]          core_mask_i,
    input  logic [ADDR_W-1:0]   vec_base_i,
    input  logic [1:0]          fast_en_i,
    input  logic [SRC_W-1:0]    fast_src0_i,
    input  logic [SRC_W-1:0]    fast_src1_i,
    input  logic [ADDR_W-1:0]   fast_addr0_i,
    input  logic [ADDR_W-1:0]   fast_addr1_i,
    output logic                irq_valid_o,
    output logic [SRC_W-1:0]    irq_src_o,
    output logic [2:0]          irq_lvl_o,
    output logic [ADDR_W-1:0]   irq_vec_o,
    output logic                irq_fast_o,
    output logic                wake_o
);

    logic [RANK_W*NUM_SRC-1:0] rank_flat;
    logic [NUM_SRC-1:0]        unmask;
    logic                      wake_c;
    logic                      win_valid;
    logic [SRC_W-1:0]          win_src;
    logic [RANK_W-1:0]         win_rank;
    logic [ADDR_W-1:0]         vec_c;
    logic                      fast_c;

    nic_rank_map #(.NUM_SRC(NUM_SRC), .NUM_NMI(NUM_NMI), .NUM_ML3(NUM_ML3)) u_map (
        .req_i       (req_i),
        .en_i        (en_i),
        .lvl_cfg_i   (lvl_cfg_i),
        .rank_flat_o (rank_flat),
        .unmask_o    (unmask),
        .wake_o      (wake_c)
    );

    nic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .rank_flat_i (rank_flat),
        .unmask_i    (unmask),
        .core_mask_i (core_mask_i),
        .win_valid_o (win_valid),
        .win_src_o   (win_src),
        .win_rank_o  (win_rank)
    );

    nic_vector #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_vec (
        .win_valid_i  (win_valid),
        .win_src_i    (win_src),
        .vec_base_i   (vec_base_i),
        .fast_en_i    (fast_en_i),
        .fast_src0_i  (fast_src0_i),
        .fast_src1_i  (fast_src1_i),
        .fast_addr0_i (fast_addr0_i),
        .fast_addr1_i (fast_addr1_i),
        .vec_o        (vec_c),
        .fast_o       (fast_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid_o <= 1'b0;
            irq_src_o   <= '0;
            irq_lvl_o   <= '0;
            irq_vec_o   <= '0;
            irq_fast_o  <= 1'b0;
            wake_o      <= 1'b0;
        end else begin
            irq_valid_o <= win_valid;
            irq_src_o   <= win_src;
            irq_lvl_o   <= win_rank;
            irq_vec_o   <= vec_c;
            irq_fast_o  <= fast_c;
            wake_o      <= wake_c;
        end
    end

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int NUM_SRC = 16,
    parameter int NUM_NMI = 4,
    parameter int ADDR_W  = 16,
    localparam int SRC_W = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] req_i,
    input logic [2:0]         core_mask_i,
    input logic [ADDR_W-1:0]  vec_base_i,
    input logic [ADDR_W-1:0]  fast_addr0_i,
    input logic [ADDR_W-1:0]  fast_addr1_i,
    input logic               irq_valid_o,
    input logic [SRC_W-1:0]   irq_src_o,
    input logic [2:0]         irq_lvl_o,
    input logic [ADDR_W-1:0]  irq_vec_o,
    input logic               irq_fast_o,
    input logic               wake_o
);

    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_valid_o && !wake_o && !irq_fast_o));

    assert_unmask_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(|req_i[NUM_NMI-1:0])) |->
        (irq_valid_o && (int'(irq_src_o) < NUM_NMI)));

    assert_strict_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && irq_valid_o && (int'(irq_src_o) >= NUM_NMI)) |->
        (irq_lvl_o > $past(core_mask_i)));

    assert_vector_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && irq_valid_o && !irq_fast_o) |->
        (irq_vec_o == $past(vec_base_i) + (ADDR_W'(irq_src_o) << 1)));

    assert_fast_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && irq_fast_o) |->
        (irq_valid_o && ((irq_vec_o == $past(fast_addr0_i)) ||
                         (irq_vec_o == $past(fast_addr1_i)))));

    assert_wake_R10: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> wake_o);

endmodule

bind nest_irq_ctrl nic_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_NMI (NUM_NMI),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .core_mask_i  (core_mask_i),
    .vec_base_i   (vec_base_i),
    .fast_addr0_i (fast_addr0_i),
    .fast_addr1_i (fast_addr1_i),
    .irq_valid_o  (irq_valid_o),
    .irq_src_o    (irq_src_o),
    .irq_lvl_o    (irq_lvl_o),
    .irq_vec_o    (irq_vec_o),
    .irq_fast_o   (irq_fast_o),
    .wake_o       (wake_o)
);

// File: tb/tb_nest_irq_ctrl.sv
`timescale 1ns/1ps
module tb_nest_irq_ctrl;

    localparam int N    = 16;
    localparam int NMI  = 4;
    localparam int ML3  = 3;
    localparam int AW   = 16;
    localparam int SW   = 4;
    localparam int NMSK = N - NMI;
    localparam int NUSR = N - NMI - ML3 - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]      req = '0;
    logic [NMSK-1:0]   en = '0;
    logic [2*NUSR-1:0] cfg = '0;
    logic [2:0]        mask = '0;
    logic [AW-1:0]     base = '0;
    logic [1:0]        fen = '0;
    logic [SW-1:0]     fs0 = '0, fs1 = '0;
    logic [AW-1:0]     fa0 = '0, fa1 = '0;

    logic          o_valid, o_fast, o_wake;
    logic [SW-1:0] o_src;
    logic [2:0]    o_lvl;
    logic [AW-1:0] o_vec;

    int checks = 0;
    int fails  = 0;

    int e_valid, e_src, e_lvl, e_vec, e_fast, e_wake;

    always #2.5 clk = ~clk;

    nest_irq_ctrl #(.NUM_SRC(N), .NUM_NMI(NMI), .NUM_ML3(ML3), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .req_i(req), .en_i(en), .lvl_cfg_i(cfg),
        .core_mask_i(mask), .vec_base_i(base), .fast_en_i(fen),
        .fast_src0_i(fs0), .fast_src1_i(fs1), .fast_addr0_i(fa0), .fast_addr1_i(fa1),
        .irq_valid_o(o_valid), .irq_src_o(o_src), .irq_lvl_o(o_lvl),
        .irq_vec_o(o_vec), .irq_fast_o(o_fast), .wake_o(o_wake)
    );

    // Behavioural expectation taken from the requirements.
    task automatic model();
        int best_r, best_i;
        bit any;
        best_r = 0; best_i = 0; any = 0;
        for (int i = 0; i < N; i++) begin
            int r;
            bit hard;
            hard = (i < NMI);
            r = 0;
            if (req[i]) begin
                if (hard) r = 5;
                else if (en[i-NMI]) begin
                    if (i < NMI + ML3) r = 5;
                    else if (i == N - 1) r = 1;
                    else if (cfg[2*(i-NMI-ML3) +: 2] != 2'd3)
                        r = int'(cfg[2*(i-NMI-ML3) +: 2]) + 2;
                end
            end
            if (r > 0) any = 1;
            if (r > 0 && (hard || r > int'(mask)) && r > best_r) begin
                best_r = r; best_i = i;
            end
        end
        e_wake = any; e_valid = (best_r > 0); e_src = best_i; e_lvl = best_r;
        e_fast = 0; e_vec = 0;
        if (e_valid) begin
            if (fen[0] && best_i == int'(fs0)) begin e_fast = 1; e_vec = int'(fa0); end
            else if (fen[1] && best_i == int'(fs1)) begin e_fast = 1; e_vec = int'(fa1); end
            else e_vec = (int'(base) + 2 * best_i) % (1 << AW);
        end
        if (rst) begin
            e_valid = 0; e_src = 0; e_lvl = 0; e_vec = 0; e_fast = 0; e_wake = 0;
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model();
        @(negedge clk);
        checks++;
        if (int'(o_valid) != e_valid || int'(o_src) != e_src || int'(o_lvl) != e_lvl ||
            int'(o_vec) != e_vec || int'(o_fast) != e_fast || int'(o_wake) != e_wake) begin
            fails++;
            $display("FAIL %s: got v=%0d s=%0d l=%0d vec=%h f=%0d w=%0d exp v=%0d s=%0d l=%0d vec=%h f=%0d w=%0d",
                     tag, o_valid, o_src, o_lvl, o_vec, o_fast, o_wake,
                     e_valid, e_src, e_lvl, e_vec, e_fast, e_wake);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        // R1: reset holds outputs low even with requests present
        req = '1; en = '1;
        step("R1");
        step("R1");
        req = '0; en = '0; rst = 1'b0;
        step("R11");
        base = 16'h1000;
        // R4 / R8: lone ordinary source 8 at level 1 (code 1)
        en = '1; cfg = '0; cfg[2*(8-7) +: 2] = 2'd1; req[8] = 1'b1; mask = 3'd0;
        step("R4");
        step("R8");
        // R6: mask 3 equals rank 3 -> blocked, mask 2 accepted
        mask = 3'd3; step("R6");
        mask = 3'd2; step("R6");
        // R7: equal level, lower number wins
        cfg[2*(12-7) +: 2] = 2'd1; req[12] = 1'b1; mask = 3'd0; step("R7");
        // R7: higher level wins over lower number
        cfg[2*(12-7) +: 2] = 2'd2; step("R7");
        // R4: code 3 removes the source
        cfg[2*(12-7) +: 2] = 2'd3; cfg[2*(8-7) +: 2] = 2'd3; step("R4");
        req = '0;
        // R5: software lowest level
        req[15] = 1'b1; mask = 3'd0; step("R5");
        mask = 3'd1; step("R5");
        // R10: masked but enabled request still wakes
        step("R10");
        en[15-NMI] = 1'b0; step("R10");
        req = '0; en = '1;
        // R3: maskable top level
        req[5] = 1'b1; mask = 3'd4; step("R3");
        mask = 3'd5; step("R3");
        mask = 3'd4; en[5-NMI] = 1'b0; step("R3");
        // R2: unmaskable ignores mask and beats maskable top level
        en = '1; req[2] = 1'b1; mask = 3'd7; step("R2");
        mask = 3'd0; step("R2");
        req = '0;
        // R9: fast slots, slot 0 precedence
        base = 16'hfff0; req[14] = 1'b1; cfg[2*(14-7) +: 2] = 2'd0;
        fs0 = 4'd14; fs1 = 4'd14; fa0 = 16'h0a0a; fa1 = 16'h0b0b; fen = 2'b11;
        step("R9");
        fen = 2'b10; step("R9");
        fen = 2'b00; step("R8");
        // R11: reset in the middle clears outputs, release resumes
        rst = 1'b1; step("R1");
        rst = 1'b0; step("R11");
        for (int k = 0; k < 400; k++) begin
            req  = N'($urandom);
            en   = NMSK'($urandom);
            cfg  = (2*NUSR)'($urandom);
            mask = 3'($urandom);
            base = AW'($urandom);
            fen  = 2'($urandom);
            fs0  = SW'($urandom);
            fs1  = SW'($urandom);
            fa0  = AW'($urandom);
            fa1  = AW'($urandom);
            if (k % 3 == 0) req[NMI-1:0] = '0;
            step("R7");
        end
        finish_run();
    end

endmodule